// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

The block sits on the receive side of an Ethernet MAC. It watches the start of each incoming frame one byte at a time and, once the sixth byte of the destination address has arrived, it gives a single accept or drop verdict for that frame. The verdict can follow from any of these rules: an exact match against a table of unicast address slots, a lookup in a 64-bit multicast hash table, the fixed broadcast address, or one of several override modes.

The byte stream has a byte-valid strobe and a start-of-frame marker, which is raised together with the first destination byte. The multicast hash index is taken from a reflected CRC-32. The CRC is updated once per byte while the address streams in, so the verdict needs no second pass over the address. Slot 0 holds the station's own address. Slots 1 and above hold extra unicast addresses, each with its own valid bit. The payload, the frame check sequence and all register access are handled elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: After a synchronous active-low reset, `verdict_valid` and `verdict_accept` are low, and no verdict comes out until a frame starts with `rx_sof`.
- R2: `verdict_valid` is high for exactly one cycle. That cycle directly follows the clock edge that captures the sixth valid destination byte. Cycles with `rx_valid` low do not count as bytes. Bytes after the sixth produce no further verdict.
- R3: A byte with `rx_sof` high restarts address capture at the first byte, even when it arrives in the middle of an address. Bytes that arrive before any start of frame are ignored.
- R4: The first received byte is the most significant octet of the 48-bit address (bits 47:40 of a slot value). A unicast frame is accepted when its address equals a slot whose valid bit is set. Slot 0 is the station address. A slot whose valid bit is clear never matches.
- R5: A unicast frame is one where bit 0 of the first byte is 0. Such a frame is dropped when it matches no valid slot and no override mode is set.
- R6: With `hash_mcast_en` set, a multicast frame is accepted exactly when the hash table bit at the index is set. The index is computed as follows. A CRC-32 (reflected polynomial 0xEDB88320, register preset to all ones) runs over the six bytes, each byte taken LSB first. The result is inverted and bit-reversed, and its top 6 bits form the index. Index bit 5 selects the upper word `hash_table[63:32]` or the lower word `hash_table[31:0]`. Index bits 4:0 select the bit within that word.
- R7: A multicast frame (bit 0 of the first byte is 1) is dropped when no multicast mode is enabled. With `pass_mcast_en` set it is accepted whatever the hash table holds.
- R8: The broadcast address FF:FF:FF:FF:FF:FF is always accepted, with every mode bit clear.
- R9: With `promisc_en` set, every frame is accepted.
- R10: With `rx_all_en` set, every frame is accepted, overriding all other filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sof | input | 1 | Start of frame, high with the first destination byte |
| rx_valid | input | 1 | Byte strobe for `rx_byte` |
| rx_byte | input | 8 | Received byte |
| promisc_en | input | 1 | Accept every frame |
| pass_mcast_en | input | 1 | Accept every multicast frame |
| hash_mcast_en | input | 1 | Filter multicast frames through the hash table |
| rx_all_en | input | 1 | Accept every frame, overriding all filtering |
| hash_table | input | 64 | Multicast hash table; bit n is entry n |
| slot_addr | input | NUM_SLOTS*48 | Unicast slot addresses; slot i is bits i*48 +: 48 |
| slot_valid | input | NUM_SLOTS | Valid bit per unicast slot |
| verdict_valid | output | 1 | One-cycle pulse marking a verdict |
| verdict_accept | output | 1 | Verdict: 1 = accept, 0 = drop; meaningful only with `verdict_valid` |

## Verification
The bench builds the filter with NUM_SLOTS = 5, which is the station slot plus four extra slots. With that size the highest slot and an invalid slot can both be exercised in a few frames. The hash width stays at its default of 6 index bits, so the full 64-entry table is in use. The bench searches a range of multicast addresses for one whose index falls in the upper word and one whose index falls in the lower word, so that both word selections are covered. It also drives frames with idle gaps, with trailing bytes and with a restart in the middle of an address, to cover the byte-counting rules.

// File: rtl/raf_pkg.sv
// Shared constants and the byte-wise CRC step for the receive address filter.
// Assumes a reflected CRC-32 with the register preset to all ones.
package raf_pkg;
    localparam int ADDR_W   = 48;
    localparam int BYTE_W   = 8;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

    // One byte of the reflected CRC: fold the byte in, then shift eight times.
    function automatic logic [31:0] crc_byte(input logic [31:0] c,
                                             input logic [BYTE_W-1:0] d);
        logic [31:0] r;
        r = c ^ {{(32-BYTE_W){1'b0}}, d};
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/raf_capture.sv
// Address capture: counts destination bytes after a start of frame, shifts
// them into an address register and updates the CRC once per byte.
// The outputs addr_now and crc_now already include the byte being presented,
// so the parent can decide in the same cycle as the sixth byte.
// Assumes rx_sof is only meaningful together with rx_valid.
module raf_capture
    import raf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              last_byte,
    output logic [ADDR_W-1:0] addr_now,
    output logic [31:0]       crc_now
);
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
    localparam int HOLD_W = ADDR_W - BYTE_W;
    localparam logic [CNT_W-1:0] DONE = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [HOLD_W-1:0] addr_q;
    logic [31:0]       crc_q;

    logic              take;
    logic [CNT_W-1:0]  cnt_eff;
    logic [HOLD_W-1:0] addr_base;
    logic [31:0]       crc_base;

    // Select the starting point: a start of frame resets count, address and CRC.
    always_comb begin
        cnt_eff   = rx_sof ? '0 : cnt_q;
        addr_base = rx_sof ? '0 : addr_q;
        crc_base  = rx_sof ? '1 : crc_q;
        take      = rx_valid && (rx_sof || (cnt_q != DONE));
        addr_now  = {addr_base, rx_byte};
        crc_now   = crc_byte(crc_base, rx_byte);
        last_byte = take && (cnt_eff == LAST);
    end

    // Advance the byte counter and capture state on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= DONE;
            addr_q <= '0;
            crc_q  <= '1;
        end else if (take) begin
            cnt_q  <= cnt_eff + CNT_W'(1);
            addr_q <= addr_now[HOLD_W-1:0];
            crc_q  <= crc_now;
        end
    end

    // R2: the counter never runs past the address length.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DONE);

    // R3: a start-of-frame byte always leaves exactly one byte counted.
    a_r3_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && rx_valid) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/raf_hash_lookup.sv
// Multicast hash lookup: forms the table index from the low CRC bits
// (inverted and mirrored, which equals the top bits of the inverted and
// bit-reversed CRC) and selects the table bit. The index MSB picks the
// upper or lower half of the table. Purely combinational.
module raf_hash_lookup #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0]      crc_low,
    input  logic [(1<<IDX_W)-1:0] table_bits,
    output logic [IDX_W-1:0]      index,
    output logic                  hit
);
    localparam int HALF = (1 << IDX_W) / 2;

    // Mirror and invert each CRC bit into the index.
    for (genvar i = 0; i < IDX_W; i++) begin : g_idx
        assign index[i] = ~crc_low[IDX_W-1-i];
    end

    logic [HALF-1:0] word_sel;

    // Pick the table half by index MSB, then the bit by the remaining bits.
    always_comb begin
        word_sel = index[IDX_W-1] ? table_bits[2*HALF-1:HALF] : table_bits[HALF-1:0];
        hit      = word_sel[index[IDX_W-2:0]];
    end
endmodule

// File: rtl/raf_slot_match.sv
// Perfect unicast match: compares the captured address with every slot and
// reports a hit when any slot with its valid bit set is equal. Slot 0 is the
// station address; the rest are extra addresses. Purely combinational.
module raf_slot_match
    import raf_pkg::*;
#(
    parameter int NUM_SLOTS = 17
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr,
    input  logic [NUM_SLOTS-1:0]        slot_valid,
    output logic                        hit
);
    logic [NUM_SLOTS-1:0] eq;

    // One comparator per slot, gated by its valid bit.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign eq[s] = slot_valid[s] && (slot_addr[s*ADDR_W +: ADDR_W] == addr);
    end

    assign hit = |eq;
endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination address filter, top level. Combines the perfect unicast
// match, the multicast hash lookup, the broadcast rule and the override modes,
// and registers one verdict per frame one cycle after the sixth address byte.
// Assumes the mode bits and tables are stable while an address is received.
module rx_addr_filter
    import raf_pkg::*;
#(
    parameter int NUM_SLOTS  = 17,
    parameter int HASH_IDX_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_sof,
    input  logic                        rx_valid,
    input  logic [7:0]                  rx_byte,
    input  logic                        promisc_en,
    input  logic                        pass_mcast_en,
    input  logic                        hash_mcast_en,
    input  logic                        rx_all_en,
    input  logic [(1<<HASH_IDX_W)-1:0]  hash_table,
    input  logic [NUM_SLOTS*48-1:0]     slot_addr,
    input  logic [NUM_SLOTS-1:0]        slot_valid,
    output logic                        verdict_valid,
    output logic                        verdict_accept
);
    localparam int MCAST_BIT = ADDR_W - BYTE_W;

    logic              last_byte;
    logic [ADDR_W-1:0] addr_now;
    logic [31:0]       crc_now;
    logic              slot_hit;
    logic              hash_hit;
    logic [HASH_IDX_W-1:0] hash_index;
    logic              is_mcast;
    logic              is_bcast;
    logic              accept_now;

    raf_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_sof    (rx_sof),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .last_byte (last_byte),
        .addr_now  (addr_now),
        .crc_now   (crc_now)
    );

    raf_hash_lookup #(.IDX_W(HASH_IDX_W)) u_hash (
        .crc_low    (crc_now[HASH_IDX_W-1:0]),
        .table_bits (hash_table),
        .index      (hash_index),
        .hit        (hash_hit)
    );

    raf_slot_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
        .addr       (addr_now),
        .slot_addr  (slot_addr),
        .slot_valid (slot_valid),
        .hit        (slot_hit)
    );

    // Combine address class, lookups and override modes into one decision.
    always_comb begin
        is_mcast   = addr_now[MCAST_BIT];
        is_bcast   = &addr_now;
        accept_now = rx_all_en || promisc_en || is_bcast
                  || (is_mcast && (pass_mcast_en || (hash_mcast_en && hash_hit)))
                  || (!is_mcast && slot_hit);
    end

    // Register the verdict on the edge that takes the last address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end else begin
            verdict_valid  <= last_byte;
            verdict_accept <= last_byte && accept_now;
        end
    end

    // R2: a verdict follows the final address byte by exactly one cycle.
    a_r2_verdict_timing: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte |=> verdict_valid);

    // R2: a verdict is a single-cycle pulse.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);

    // R8: the broadcast address is always accepted.
    a_r8_bcast_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && (&addr_now)) |=> verdict_accept);

    // R9: promiscuous mode accepts every frame.
    a_r9_promisc_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && promisc_en) |=> verdict_accept);

    // R10: receive-all mode accepts every frame.
    a_r10_rx_all_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && rx_all_en) |=> verdict_accept);

    // R7: with no multicast mode or override, a non-broadcast multicast frame is dropped.
    a_r7_mcast_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && addr_now[MCAST_BIT] && !(&addr_now) && !pass_mcast_en
         && !hash_mcast_en && !promisc_en && !rx_all_en) |=> !verdict_accept);
endmodule

// File: tb/rx_addr_filter_bench.sv
// Directed bench for the receive address filter, one task per scenario.
module rx_addr_filter_bench;
    localparam int SLOTS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_sof = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic promisc_en = 1'b0;
    logic pass_mcast_en = 1'b0;
    logic hash_mcast_en = 1'b0;
    logic rx_all_en = 1'b0;
    logic [63:0] hash_table = 64'h0;
    logic [SLOTS*48-1:0] slot_addr = '0;
    logic [SLOTS-1:0] slot_valid = '0;
    logic verdict_valid;
    logic verdict_accept;

    int n_tests = 0;
    int n_fail = 0;

    localparam logic [47:0] STATION = 48'h0012_3456_789A;
    localparam logic [47:0] EXTRA4  = 48'h00AA_BBCC_DD04;
    localparam logic [47:0] EXTRA2  = 48'h00AA_BBCC_DD02;
    localparam logic [47:0] MISS    = 48'h0066_7788_99AA;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

    always #5 clk = ~clk;

    rx_addr_filter #(.NUM_SLOTS(SLOTS)) u_rx_addr_filter (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_sof         (rx_sof),
        .rx_valid       (rx_valid),
        .rx_byte        (rx_byte),
        .promisc_en     (promisc_en),
        .pass_mcast_en  (pass_mcast_en),
        .hash_mcast_en  (hash_mcast_en),
        .rx_all_en      (rx_all_en),
        .hash_table     (hash_table),
        .slot_addr      (slot_addr),
        .slot_valid     (slot_valid),
        .verdict_valid  (verdict_valid),
        .verdict_accept (verdict_accept)
    );

    task automatic check(input logic cond, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Hash index per R6, bit-serial CRC, LSB of each byte first.
    function automatic logic [5:0] hash_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] rev;
        for (int b = 0; b < 6; b++) begin
            logic [7:0] d = a[47-8*b -: 8];
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ d[i];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        c = ~c;
        for (int i = 0; i < 32; i++) rev[i] = c[31-i];
        return rev[31:26];
    endfunction

    // Send six address bytes with an optional idle gap after each, then
    // check the verdict pulse one cycle after the sixth byte.
    task automatic send_check(input logic [47:0] a, input int gap,
                              input logic exp_acc, input string tag);
        for (int b = 0; b < 6; b++) begin
            @(negedge clk);
            rx_sof   = (b == 0);
            rx_valid = 1'b1;
            rx_byte  = a[47-8*b -: 8];
            if (b < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    rx_sof = 1'b0;
                    rx_valid = 1'b0;
                    check(verdict_valid == 1'b0, tag, "early verdict", verdict_valid, 0);
                end
            end
        end
        @(negedge clk);
        rx_sof = 1'b0;
        rx_valid = 1'b0;
        check(verdict_valid == 1'b1, tag, "verdict_valid", verdict_valid, 1);
        check(verdict_accept == exp_acc, tag, "verdict_accept", verdict_accept, exp_acc);
        @(negedge clk);
        check(verdict_valid == 1'b0, tag, "pulse end", verdict_valid, 0);
    endtask

    task automatic clear_modes();
        promisc_en = 0; pass_mcast_en = 0; hash_mcast_en = 0; rx_all_en = 0;
        hash_table = 64'h0;
    endtask

    task automatic t_reset();
        // R1: outputs low after reset, stray bytes before any sof ignored (R3).
        @(negedge clk);
        check(verdict_valid == 0, "R1", "valid after reset", verdict_valid, 0);
        check(verdict_accept == 0, "R1", "accept after reset", verdict_accept, 0);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            rx_valid = 1; rx_byte = 8'hFF;
        end
        @(negedge clk);
        rx_valid = 0;
        check(verdict_valid == 0, "R3", "no verdict without sof", verdict_valid, 0);
        @(negedge clk);
        check(verdict_valid == 0, "R1", "no verdict without sof", verdict_valid, 0);
    endtask

    task automatic t_unicast();
        clear_modes();
        send_check(STATION, 0, 1'b1, "R4");   // slot 0
        send_check(EXTRA4,  0, 1'b1, "R4");   // highest slot
        send_check(EXTRA2,  0, 1'b0, "R4");   // slot 2 not valid
        send_check(MISS,    0, 1'b0, "R5");
    endtask

    task automatic t_hash();
        logic [47:0] hi_a = '0;
        logic [47:0] lo_a = '0;
        logic found_hi = 0;
        logic found_lo = 0;
        for (int k = 0; k < 256; k++) begin
            logic [47:0] a = {40'h01_005E_0000, 8'(k)};
            if (hash_index(a) >= 6'd32 && !found_hi) begin hi_a = a; found_hi = 1; end
            if (hash_index(a) <  6'd32 && !found_lo) begin lo_a = a; found_lo = 1; end
        end
        clear_modes();
        hash_mcast_en = 1;
        hash_table = 64'h1 << hash_index(hi_a);
        send_check(hi_a, 0, 1'b1, "R6");      // upper word hit
        hash_table = ~(64'h1 << hash_index(hi_a));
        send_check(hi_a, 0, 1'b0, "R6");      // only its bit clear
        hash_table = 64'h1 << hash_index(lo_a);
        send_check(lo_a, 0, 1'b1, "R6");      // lower word hit
        hash_table = 64'h1 << (hash_index(lo_a) ^ 6'd32);
        send_check(lo_a, 0, 1'b0, "R6");      // same bit, wrong word
        clear_modes();
        hash_table = 64'hFFFF_FFFF_FFFF_FFFF;
        send_check(lo_a, 0, 1'b0, "R7");      // no multicast mode
        hash_table = 64'h0;
        pass_mcast_en = 1;
        send_check(hi_a, 0, 1'b1, "R7");
        send_check(MISS, 0, 1'b0, "R7");      // unicast unaffected
    endtask

    task automatic t_overrides();
        clear_modes();
        send_check(BCAST, 0, 1'b1, "R8");
        promisc_en = 1;
        send_check(MISS, 0, 1'b1, "R9");
        send_check(48'h0100_5E00_0001, 0, 1'b1, "R9");
        clear_modes();
        rx_all_en = 1;
        send_check(MISS, 0, 1'b1, "R10");
        send_check(48'h0300_0000_0042, 0, 1'b1, "R10");
        clear_modes();
    endtask

    task automatic t_stream();
        clear_modes();
        // R2: idle gaps between bytes
        send_check(STATION, 2, 1'b1, "R2");
        // R2: trailing bytes give no second verdict
        for (int b = 0; b < 6; b++) begin
            @(negedge clk);
            rx_sof = (b == 0); rx_valid = 1; rx_byte = MISS[47-8*b -: 8];
        end
        @(negedge clk);
        rx_sof = 0; rx_byte = 8'h11;
        check(verdict_valid == 1, "R2", "verdict with trailing", verdict_valid, 1);
        check(verdict_accept == 0, "R2", "miss dropped", verdict_accept, 0);
        for (int b = 0; b < 6; b++) begin
            @(negedge clk);
            check(verdict_valid == 0, "R2", "trailing byte verdict", verdict_valid, 0);
        end
        rx_valid = 0;
        // R3: restart in the middle of an address
        for (int b = 0; b < 3; b++) begin
            @(negedge clk);
            rx_sof = (b == 0); rx_valid = 1; rx_byte = MISS[47-8*b -: 8];
        end
        send_check(STATION, 0, 1'b1, "R3");
    endtask

    initial begin
        slot_addr[0*48 +: 48] = STATION;
        slot_addr[2*48 +: 48] = EXTRA2;
        slot_addr[4*48 +: 48] = EXTRA4;
        slot_valid = 5'b10001;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_unicast();
        t_hash();
        t_overrides();
        t_stream();
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        report();
    end
endmodule